// File: doc/BRIEF.md
# Data-Strobe Collision Checker for Read and Write Bursts

This block decides whether a proposed read or write burst, with or without automatic precharge, may be placed at a proposed start cycle without clashing on the shared data strobe with bursts that are already in flight. From the command kind, the start cycle, the burst length and the timing parameters, it computes the burst's command end cycle and its data-strobe window. It then compares that window with every live entry of a small in-flight table and raises a collision flag.

A scheduling wrapper presents a candidate, reads the collision flag and the bank flags, and if either forbids issue, moves the start forward one cycle and tries again. Once a start is accepted, it pulses the commit input so that the burst joins the table. Entries whose command end lies before the current cycle take no further part in the comparison and are removed at the next clock edge. The bank-order inputs check the predecessor on the target bank. After an activate, the burst must wait for the activate's end cycle, and any predecessor other than an activate, a read or a write is flagged as an ordering error.

Top module: `dq_clash_checker`

## Requirements
- R1: For a read (kind 0) the data window is [start, start+tRL+BL] and end_o equals its close. A read with auto-precharge (kind 1) has the same data window, and end_o is larger by tRP.
- R2: For a write (kind 2) the data window is [start, start+tWL+BL-1] and end_o equals its close. A write with auto-precharge (kind 3) has the same data window, and end_o is larger by tRP.
- R3: Two reads collide when the start of either one lies inside the other's closed data window and their starts differ by an odd number of cycles. An even offset never collides. The auto-precharge tail is not part of the window.
- R4: A write whose start is at or after a live read's start collides unless it starts at or after that read's data-window end.
- R5: A read whose start is at or after a live write's start collides unless it starts at or after that write's data-window end plus tWTR.
- R6: Two writes never collide on the data strobe.
- R7: With the predecessor code 1 (activate), bank_wait_o is high while the start is before act_end_i. Code 3 (anything other than activate, read or write) raises order_err_o. Codes 0 (none) and 2 (read/write) raise neither flag.
- R8: An entry whose command end is below now_i is ignored by the comparison and by fill_o at once, and is removed at the next clock edge.
- R9: The table holds DEPTH (8) entries. A commit when all entries are live drops the new burst and sets overflow_o, which stays set until reset.
- R10: During reset and after it, the table is empty: fill_o is 0, overflow_o is 0 and collide_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_i | input | CW | Current cycle, used for pruning |
| prop_kind_i | input | 2 | Candidate kind: bit 1 write, bit 0 auto-precharge |
| prop_start_i | input | CW | Candidate start cycle |
| prop_bl_i | input | BLW | Candidate burst length in cycles |
| trl_i | input | TW | Read latency |
| twl_i | input | TW | Write latency |
| trp_i | input | TW | Precharge time |
| twtr_i | input | TW | Write-to-read turnaround |
| pred_i | input | 2 | Bank predecessor code (see R7) |
| act_end_i | input | CW | End cycle of the predecessor activate |
| commit_i | input | 1 | Insert the candidate into the table at the next edge |
| collide_o | output | 1 | Candidate clashes with a live entry |
| bank_wait_o | output | 1 | Candidate starts before the activate has ended |
| order_err_o | output | 1 | Illegal predecessor on the bank |
| end_o | output | CW | Candidate command end cycle |
| dq_start_o | output | CW | Candidate data-window start |
| dq_end_o | output | CW | Candidate data-window end |
| fill_o | output | FW | Number of live entries |
| overflow_o | output | 1 | Sticky insert-overflow flag |

## Verification
The candidate outputs (collide_o, the window and end cycles, and the bank flags) are combinational from the inputs and the table, so the bench drives them on a falling edge and samples them one nanosecond later, within the same cycle. A commit and a prune take effect at the next rising edge, so fill_o, overflow_o and any collision against a new entry are sampled after the falling edge that follows that rising edge. The internal reset is released two edges after rst_n rises, and the bench waits for those edges before it checks anything that depends on the table.

// File: rtl/dq_clash_pkg.sv
package dq_clash_pkg;
  localparam logic [1:0] KIND_RD  = 2'd0;
  localparam logic [1:0] KIND_RDA = 2'd1;
  localparam logic [1:0] KIND_WR  = 2'd2;
  localparam logic [1:0] KIND_WRA = 2'd3;

  localparam logic [1:0] PRED_NONE  = 2'd0;
  localparam logic [1:0] PRED_ACT   = 2'd1;
  localparam logic [1:0] PRED_RW    = 2'd2;
  localparam logic [1:0] PRED_OTHER = 2'd3;
endpackage

// File: rtl/dq_span.sv
module dq_span #(
  parameter int CW  = 16,
  parameter int TW  = 4,
  parameter int BLW = 4
) (
  input  logic [1:0]     kind_i,
  input  logic [CW-1:0]  start_i,
  input  logic [BLW-1:0] bl_i,
  input  logic [TW-1:0]  trl_i,
  input  logic [TW-1:0]  twl_i,
  input  logic [TW-1:0]  trp_i,
  output logic [CW-1:0]  dq_end_o,
  output logic [CW-1:0]  cmd_end_o
);
  logic [CW-1:0] lat;

  always_comb begin
    if (kind_i[1]) lat = CW'(twl_i) + CW'(bl_i) - CW'(1);
    else           lat = CW'(trl_i) + CW'(bl_i);
    dq_end_o  = start_i + lat;
    cmd_end_o = dq_end_o + (kind_i[0] ? CW'(trp_i) : '0);
  end
endmodule

// File: rtl/pair_clash.sv
module pair_clash #(
  parameter int CW = 16,
  parameter int TW = 4
) (
  input  logic          p_wr_i,
  input  logic [CW-1:0] p_s_i,
  input  logic [CW-1:0] p_de_i,
  input  logic          e_wr_i,
  input  logic [CW-1:0] e_s_i,
  input  logic [CW-1:0] e_de_i,
  input  logic [TW-1:0] twtr_i,
  output logic          clash_o
);
  logic later, overlap, odd_off;

  always_comb begin
    later   = (e_s_i >= p_s_i);
    overlap = (later && e_s_i <= p_de_i) || (!later && p_s_i <= e_de_i);
    odd_off = p_s_i[0] ^ e_s_i[0];
    unique case ({p_wr_i, e_wr_i})
      2'b00: clash_o = overlap && odd_off;
      2'b10: clash_o = later ? (e_s_i < p_de_i + CW'(twtr_i)) : (p_s_i < e_de_i);
      2'b01: clash_o = later ? (e_s_i < p_de_i) : (p_s_i < e_de_i + CW'(twtr_i));
      default: clash_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/inflight_list.sv
module inflight_list #(
  parameter int DEPTH = 8,
  parameter int CW    = 16,
  parameter int TW    = 4,
  parameter int FW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] now_i,
  input  logic          commit_i,
  input  logic          p_wr_i,
  input  logic [CW-1:0] p_s_i,
  input  logic [CW-1:0] p_de_i,
  input  logic [CW-1:0] p_ce_i,
  input  logic [TW-1:0] twtr_i,
  output logic          hit_o,
  output logic [FW-1:0] fill_o,
  output logic          ovf_o
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld_q, vld_d, live, clash, we;
  logic [DEPTH-1:0] wr_q;
  logic [CW-1:0]    s_q  [DEPTH];
  logic [CW-1:0]    de_q [DEPTH];
  logic [CW-1:0]    ce_q [DEPTH];
  logic [IW-1:0]    sel;
  logic             has_free, ovf_q, ovf_d;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      assign live[g] = vld_q[g] && (ce_q[g] >= now_i);

      pair_clash #(.CW(CW), .TW(TW)) u_cmp (
        .p_wr_i(p_wr_i), .p_s_i(p_s_i), .p_de_i(p_de_i),
        .e_wr_i(wr_q[g]), .e_s_i(s_q[g]), .e_de_i(de_q[g]),
        .twtr_i(twtr_i), .clash_o(clash[g])
      );

      always_ff @(posedge clk) begin
        if (we[g]) begin
          wr_q[g] <= p_wr_i;
          s_q[g]  <= p_s_i;
          de_q[g] <= p_de_i;
          ce_q[g] <= p_ce_i;
        end
      end
    end
  endgenerate

  always_comb begin
    has_free = 1'b0;
    sel      = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!live[i]) begin
        has_free = 1'b1;
        sel      = IW'(i);
      end
    end
    we    = '0;
    vld_d = live;
    if (commit_i && has_free) begin
      we[sel]    = 1'b1;
      vld_d[sel] = 1'b1;
    end
    ovf_d = ovf_q | (commit_i & ~has_free);
  end

  always_comb begin
    fill_o = '0;
    for (int i = 0; i < DEPTH; i++) fill_o = fill_o + FW'(live[i]);
  end

  assign hit_o = |(live & clash);
  assign ovf_o = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      ovf_q <= ovf_d;
    end
  end
endmodule

// File: rtl/dq_clash_checker.sv
module dq_clash_checker
  import dq_clash_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = 16,
  parameter int TW    = 4,
  parameter int BLW   = 4,
  parameter int FW    = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  now_i,
  input  logic [1:0]     prop_kind_i,
  input  logic [CW-1:0]  prop_start_i,
  input  logic [BLW-1:0] prop_bl_i,
  input  logic [TW-1:0]  trl_i,
  input  logic [TW-1:0]  twl_i,
  input  logic [TW-1:0]  trp_i,
  input  logic [TW-1:0]  twtr_i,
  input  logic [1:0]     pred_i,
  input  logic [CW-1:0]  act_end_i,
  input  logic           commit_i,
  output logic           collide_o,
  output logic           bank_wait_o,
  output logic           order_err_o,
  output logic [CW-1:0]  end_o,
  output logic [CW-1:0]  dq_start_o,
  output logic [CW-1:0]  dq_end_o,
  output logic [FW-1:0]  fill_o,
  output logic           overflow_o
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic [CW-1:0] dq_end, cmd_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dq_span #(.CW(CW), .TW(TW), .BLW(BLW)) u_span (
    .kind_i(prop_kind_i), .start_i(prop_start_i), .bl_i(prop_bl_i),
    .trl_i(trl_i), .twl_i(twl_i), .trp_i(trp_i),
    .dq_end_o(dq_end), .cmd_end_o(cmd_end)
  );

  inflight_list #(.DEPTH(DEPTH), .CW(CW), .TW(TW), .FW(FW)) u_list (
    .clk(clk), .rst_n(rst_int_n), .now_i(now_i), .commit_i(commit_i),
    .p_wr_i(prop_kind_i[1]), .p_s_i(prop_start_i), .p_de_i(dq_end),
    .p_ce_i(cmd_end), .twtr_i(twtr_i),
    .hit_o(collide_o), .fill_o(fill_o), .ovf_o(overflow_o)
  );

  assign bank_wait_o = (pred_i == PRED_ACT) && (prop_start_i < act_end_i);
  assign order_err_o = (pred_i == PRED_OTHER);
  assign end_o       = cmd_end;
  assign dq_start_o  = prop_start_i;
  assign dq_end_o    = dq_end;
endmodule

module dq_clash_props #(
  parameter int DEPTH = 8,
  parameter int FW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          commit_i,
  input logic          collide_o,
  input logic [FW-1:0] fill_o,
  input logic          overflow_o
);
  p_empty_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_o == '0) |-> !collide_o);

  p_fill_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_o <= FW'(DEPTH));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow_o) |-> ($past(commit_i) && $past(fill_o) == FW'(DEPTH)));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);
endmodule

bind dq_clash_checker dq_clash_props #(.DEPTH(DEPTH), .FW(FW)) u_props (
  .clk(clk), .rst_n(rst_n), .commit_i(commit_i), .collide_o(collide_o),
  .fill_o(fill_o), .overflow_o(overflow_o)
);

// File: tb/dq_clash_checker_tb.sv
module dq_clash_checker_tb_top;
  localparam int CW = 16, TW = 4, BLW = 4, DEPTH = 8, FW = 4;

  typedef struct packed {
    logic [1:0]  ek;
    logic [15:0] es;
    logic [1:0]  pk;
    logic [15:0] ps;
    logic        exp;
    logic [3:0]  rq;
  } vec_t;

  // kinds: 0 read, 1 read+AP, 2 write, 3 write+AP; tRL=3 BL=2 tWL=1 tRP=2 tWTR=3
  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 16'd10, 2'd0, 16'd12, 1'b0, 4'd3},  // R3 even offset inside
    '{2'd0, 16'd10, 2'd0, 16'd11, 1'b1, 4'd3},  // R3 odd offset inside
    '{2'd0, 16'd10, 2'd0, 16'd15, 1'b1, 4'd3},  // R3 odd at closed end
    '{2'd0, 16'd10, 2'd0, 16'd16, 1'b0, 4'd3},  // R3 outside
    '{2'd0, 16'd10, 2'd0, 16'd9,  1'b1, 4'd3},  // R3 entry inside proposal
    '{2'd1, 16'd10, 2'd0, 16'd17, 1'b0, 4'd3},  // R3 AP tail excluded
    '{2'd0, 16'd10, 2'd2, 16'd14, 1'b1, 4'd4},  // R4 write too early
    '{2'd0, 16'd10, 2'd2, 16'd15, 1'b0, 4'd4},  // R4 write at read end
    '{2'd0, 16'd14, 2'd2, 16'd10, 1'b1, 4'd5},  // R5 read entry after write proposal
    '{2'd0, 16'd20, 2'd2, 16'd10, 1'b0, 4'd5},  // R5 read far after
    '{2'd2, 16'd10, 2'd0, 16'd14, 1'b1, 4'd5},  // R5 read inside tWTR
    '{2'd2, 16'd10, 2'd0, 16'd15, 1'b0, 4'd5},  // R5 read at end+tWTR
    '{2'd3, 16'd10, 2'd0, 16'd15, 1'b0, 4'd5},  // R5 write AP tail excluded
    '{2'd2, 16'd14, 2'd0, 16'd10, 1'b1, 4'd4},  // R4 write entry after read proposal
    '{2'd2, 16'd15, 2'd1, 16'd10, 1'b0, 4'd4},  // R4 write entry at read end
    '{2'd2, 16'd10, 2'd2, 16'd11, 1'b0, 4'd6},  // R6
    '{2'd2, 16'd10, 2'd3, 16'd10, 1'b0, 4'd6},  // R6 same start
    '{2'd3, 16'd10, 2'd2, 16'd12, 1'b0, 4'd6}   // R6
  };

  logic           clk, rst_n;
  logic [CW-1:0]  now_i, prop_start_i, act_end_i;
  logic [1:0]     prop_kind_i, pred_i;
  logic [BLW-1:0] prop_bl_i;
  logic [TW-1:0]  trl_i, twl_i, trp_i, twtr_i;
  logic           commit_i;
  logic           collide_o, bank_wait_o, order_err_o, overflow_o;
  logic [CW-1:0]  end_o, dq_start_o, dq_end_o;
  logic [FW-1:0]  fill_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  dq_clash_checker #(.DEPTH(DEPTH), .CW(CW), .TW(TW), .BLW(BLW)) dut_i (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic propose(logic [1:0] k, logic [CW-1:0] s);
    @(negedge clk);
    prop_kind_i = k; prop_start_i = s; commit_i = 1'b0;
    #1;
  endtask

  task automatic commit_one(logic [1:0] k, logic [CW-1:0] s);
    @(negedge clk);
    prop_kind_i = k; prop_start_i = s; commit_i = 1'b1;
    @(negedge clk);
    commit_i = 1'b0;
  endtask

  task automatic clear_list();
    @(negedge clk); now_i = 16'hFFF0;
    @(negedge clk); now_i = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check("R10 fill in reset", fill_o, 0);
    check("R10 overflow in reset", overflow_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    now_i = '0; prop_kind_i = '0; prop_start_i = '0; prop_bl_i = 4'd2;
    trl_i = 4'd3; twl_i = 4'd1; trp_i = 4'd2; twtr_i = 4'd3;
    pred_i = '0; act_end_i = '0; commit_i = 1'b0;
    do_reset();
    propose(2'd0, 16'd10);
    check("R10 collide after reset", collide_o, 0);

    // R1 / R2 spans
    propose(2'd0, 16'd10);
    check("R1 read end", end_o, 15); check("R1 read dq end", dq_end_o, 15);
    check("R1 dq start", dq_start_o, 10);
    propose(2'd1, 16'd10);
    check("R1 readA end", end_o, 17); check("R1 readA dq end", dq_end_o, 15);
    prop_bl_i = 4'd4; propose(2'd0, 16'd10);
    check("R1 read bl4 end", end_o, 17);
    prop_bl_i = 4'd2; propose(2'd2, 16'd10);
    check("R2 write end", end_o, 12); check("R2 write dq end", dq_end_o, 12);
    propose(2'd3, 16'd10);
    check("R2 writeA end", end_o, 14); check("R2 writeA dq end", dq_end_o, 12);

    // table: one entry then a probe
    for (int i = 0; i < NV; i++) begin
      commit_one(TBL[i].ek, TBL[i].es);
      propose(TBL[i].pk, TBL[i].ps);
      check($sformatf("R%0d vector %0d collide", TBL[i].rq, i), collide_o, TBL[i].exp);
      clear_list();
    end

    // R7 bank predecessor
    act_end_i = 16'd20; pred_i = 2'd1; propose(2'd0, 16'd18);
    check("R7 wait before act end", bank_wait_o, 1);
    propose(2'd0, 16'd20);
    check("R7 no wait at act end", bank_wait_o, 0);
    check("R7 no order error after act", order_err_o, 0);
    pred_i = 2'd3; propose(2'd0, 16'd18);
    check("R7 order error", order_err_o, 1);
    check("R7 no wait for other", bank_wait_o, 0);
    pred_i = 2'd2; propose(2'd2, 16'd5);
    check("R7 rw predecessor legal", order_err_o, 0);
    pred_i = 2'd0;

    // R8 pruning
    commit_one(2'd0, 16'd10);
    propose(2'd0, 16'd11);
    check("R8 fill one", fill_o, 1);
    @(negedge clk); now_i = 16'd15; #1;
    check("R8 live at end", collide_o, 1);
    @(negedge clk); now_i = 16'd16; #1;
    check("R8 ignored past end", collide_o, 0);
    check("R8 fill drops", fill_o, 0);
    @(negedge clk); now_i = '0; #1;
    check("R8 removed at edge", fill_o, 0);
    check("R8 removed collide", collide_o, 0);

    // R9 overflow
    for (int i = 0; i < DEPTH; i++) commit_one(2'd2, 16'(100 + i));
    #1;
    check("R9 full", fill_o, DEPTH);
    check("R9 no overflow yet", overflow_o, 0);
    commit_one(2'd0, 16'd200);
    #1;
    check("R9 overflow set", overflow_o, 1);
    check("R9 fill stays", fill_o, DEPTH);
    propose(2'd0, 16'd201);
    check("R9 dropped entry absent", collide_o, 0);
    clear_list(); #1;
    check("R9 overflow sticky", overflow_o, 1);

    do_reset();
    #1;
    check("R10 overflow cleared", overflow_o, 0);
    check("R10 fill cleared", fill_o, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 50000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule